// File: doc/BRIEF.md
# Dual-Channel Converter Output Formatter

This block sits between two converter cores and the parallel output pins of a dual-channel data converter. Each clock it takes one raw 10-bit result per channel, coded as offset binary. It carries both results through a fixed-length delay so that every word leaves the block a set number of rising edges after its sample was taken. In the last register stage it recodes the word as straight offset binary or as two's complement, according to a format-select input. The two channels always move together.

The output ports are modelled as a data bus plus a drive-enable line. An active-low output enable controls the drive enable directly, and reset does not affect it. Power-down and sleep inputs both freeze the delay path, and the output registers keep their last words. A valid flag marks output words that come from samples taken after the most recent reset, sleep or power-down. Words still in the path from before that event are never flagged.

Top module: `dual_adc_formatter`

## Requirements
- R1: A synchronous active-high reset clears every delay stage and both output words to 0, and drops `out_valid`, on the next rising edge.
- R2: A sample present on `samp_a`/`samp_b` at rising edge k, with the path advancing, is presented on `dout_a`/`dout_b` after rising edge k+LATENCY (5 by default). Edges on which the path is frozen are not counted.
- R3: With `fmt_twos` low, the output word equals the raw offset-binary code: 10_0000_0000 is zero, 00_0000_0000 is negative full scale and 11_1111_1111 is positive full scale.
- R4: With `fmt_twos` high, the output is two's complement, formed by inverting only bit 9 (the MSB): zero is 00_0000_0000, positive full scale is 01_1111_1111 and negative full scale is 10_0000_0000.
- R5: `fmt_twos` is applied at the final register, so its value at an advancing edge sets the coding of the word loaded on that edge, even if that word was sampled under the other setting.
- R6: `drive_en` equals the inverse of `oe_n` at all times, during reset and power-down too. When it is low, both buses are to be treated as high impedance.
- R7: While `pwr_dn` is high, the path does not advance and both output words keep their last value, whatever `oe_n` is.
- R8: While `sleep` is high, no new sample enters or moves through the path, and the outputs hold. Contents already in the path resume moving once sleep is released.
- R9: After reset, or after a freeze (sleep or power-down) ends, `out_valid` stays low until LATENCY+1 consecutive advancing edges have passed, so that the first new sample has reached the output. It goes low on any frozen edge.
- R10: Both channels are captured on the same edge and their output words update on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock; sampling and output updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| samp_a | input | 10 | Raw offset-binary result, channel A |
| samp_b | input | 10 | Raw offset-binary result, channel B |
| fmt_twos | input | 1 | Output coding: 0 offset binary, 1 two's complement |
| oe_n | input | 1 | Active-low output enable |
| pwr_dn | input | 1 | Power-down: freezes path and outputs |
| sleep | input | 1 | Sleep: halts both conversion paths |
| dout_a | output | 10 | Output word, channel A |
| dout_b | output | 10 | Output word, channel B |
| drive_en | output | 1 | High when the output buses are driven |
| out_valid | output | 1 | Output words come from samples taken since the last reset or freeze |

## Verification
The bench builds the block with its defaults: a width of 10 bits and a latency of 5. These values make the full-scale and zero codes of both codings directly observable, and they keep the LATENCY+1 valid window short enough to cross many times. A freeze that releases with stale words still in the five stages exercises the case where old data moves out while the valid flag must stay low. Toggling the format for a single cycle shows that the coding follows the last stage and not the capture time.

// File: rtl/adcfmt_pkg.sv
package adcfmt_pkg;

  typedef enum logic {
    CODE_OFFSET = 1'b0,
    CODE_TWOS   = 1'b1
  } code_sel_e;

  function automatic int fill_bits(input int lat);
    return $clog2(lat + 2);
  endfunction

endpackage

// File: rtl/adcfmt_delay_line.sv
module adcfmt_delay_line #(
  parameter int WIDTH = 10,
  parameter int DEPTH = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] tail
);

  logic [WIDTH-1:0] stg [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst)      stg[i] <= '0;
          else if (adv) stg[i] <= din;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (rst)      stg[i] <= '0;
          else if (adv) stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign tail = stg[DEPTH-1];

  // R8: a frozen path moves nothing toward the output
  a_r8_tail_frozen: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(tail));

  // R2: the head stage takes the sample present on an advancing edge
  a_r2_capture: assert property (@(posedge clk) disable iff (rst)
    adv |=> stg[0] == $past(din));

endmodule

// File: rtl/adcfmt_coder.sv
module adcfmt_coder
  import adcfmt_pkg::*;
#(
  parameter int WIDTH = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  code_sel_e        sel,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] dout
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] coded;

  always_comb begin
    coded = raw;
    if (sel == CODE_TWOS) coded[MSB] = ~raw[MSB];
  end

  always_ff @(posedge clk) begin
    if (rst)      dout <= '0;
    else if (adv) dout <= coded;
  end

  // R7: output word holds while frozen
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(dout));

  // R4: coding never touches bits below the MSB
  a_r4_low_bits_pass: assert property (@(posedge clk) disable iff (rst)
    adv |=> dout[MSB-1:0] == $past(raw[MSB-1:0]));

endmodule

// File: rtl/adcfmt_fill.sv
module adcfmt_fill
  import adcfmt_pkg::*;
#(
  parameter int LATENCY = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output logic valid
);

  localparam int FW = fill_bits(LATENCY);
  localparam logic [FW-1:0] FILL_MAX = FW'(LATENCY + 1);

  logic [FW-1:0] fill_q;

  always_ff @(posedge clk) begin
    if (rst || !adv)           fill_q <= '0;
    else if (fill_q != FILL_MAX) fill_q <= fill_q + 1'b1;
  end

  assign valid = (fill_q == FILL_MAX);

  // R9: any frozen edge drops the flag
  a_r9_drop_on_freeze: assert property (@(posedge clk) disable iff (rst)
    !adv |=> !valid);

  // R9: the flag only rises on an advancing edge
  a_r9_rise_on_advance: assert property (@(posedge clk) disable iff (rst)
    $rose(valid) |-> $past(adv));

endmodule

// File: rtl/dual_adc_formatter.sv
module dual_adc_formatter
  import adcfmt_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int LATENCY  = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] samp_a,
  input  logic [SAMPLE_W-1:0] samp_b,
  input  logic                fmt_twos,
  input  logic                oe_n,
  input  logic                pwr_dn,
  input  logic                sleep,
  output logic [SAMPLE_W-1:0] dout_a,
  output logic [SAMPLE_W-1:0] dout_b,
  output logic                drive_en,
  output logic                out_valid
);

  localparam int NCH = 2;

  logic                advance;
  code_sel_e           sel;
  logic [SAMPLE_W-1:0] raw   [NCH];
  logic [SAMPLE_W-1:0] tail  [NCH];
  logic [SAMPLE_W-1:0] word  [NCH];

  assign advance = !pwr_dn && !sleep;
  assign sel     = code_sel_e'(fmt_twos);
  assign raw[0]  = samp_a;
  assign raw[1]  = samp_b;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      adcfmt_delay_line #(.WIDTH(SAMPLE_W), .DEPTH(LATENCY)) u_dly (
        .clk (clk),
        .rst (rst),
        .adv (advance),
        .din (raw[c]),
        .tail(tail[c])
      );
      adcfmt_coder #(.WIDTH(SAMPLE_W)) u_code (
        .clk (clk),
        .rst (rst),
        .adv (advance),
        .sel (sel),
        .raw (tail[c]),
        .dout(word[c])
      );
    end
  endgenerate

  adcfmt_fill #(.LATENCY(LATENCY)) u_fill (
    .clk  (clk),
    .rst  (rst),
    .adv  (advance),
    .valid(out_valid)
  );

  assign dout_a   = word[0];
  assign dout_b   = word[1];
  assign drive_en = ~oe_n;

  // R1: reset clears both outputs and the flag on the next edge
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (dout_a == '0 && dout_b == '0 && !out_valid));

  // R10: channels hold together under power-down
  a_r10_lockstep_hold: assert property (@(posedge clk) disable iff (rst)
    pwr_dn |=> ($stable(dout_a) && $stable(dout_b)));

endmodule

// File: tb/dual_adc_formatter_bench.sv
module dual_adc_formatter_bench;
  localparam int W   = 10;
  localparam int LAT = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] samp_a = '0, samp_b = '0;
  logic fmt_twos = 1'b0, oe_n = 1'b0, pwr_dn = 1'b0, sleep = 1'b0;
  logic [W-1:0] dout_a, dout_b;
  logic drive_en, out_valid;

  always #2 clk = ~clk;

  dual_adc_formatter #(.SAMPLE_W(W), .LATENCY(LAT)) u_dual_adc_formatter (
    .clk(clk), .rst(rst), .samp_a(samp_a), .samp_b(samp_b),
    .fmt_twos(fmt_twos), .oe_n(oe_n), .pwr_dn(pwr_dn), .sleep(sleep),
    .dout_a(dout_a), .dout_b(dout_b), .drive_en(drive_en), .out_valid(out_valid)
  );

  typedef struct packed { logic [W-1:0] a; logic [W-1:0] b; } pair_t;
  pair_t q[$];
  int checks = 0, failures = 0;
  int adv_run = 0;
  bit have_exp = 0;
  logic [W-1:0] exp_a, exp_b;
  logic last_f = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic do_reset(input logic oen);
    rst = 1'b1; oe_n = oen;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk(dout_a == '0, "R1", "dout_a after reset", dout_a, 0);
    chk(dout_b == '0, "R1", "dout_b after reset", dout_b, 0);
    chk(out_valid == 1'b0, "R1", "valid after reset", out_valid, 0);
    chk(drive_en == !oen, "R6", "drive_en in reset", drive_en, !oen);
    q.delete(); adv_run = 0; have_exp = 0;
    rst = 1'b0;
  endtask

  // driver: applies one cycle of stimulus, pushes expected words;
  // monitor part: compares after the edge
  task automatic step(input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic f, input logic oen,
                      input logic pd, input logic sl);
    pair_t p;
    string tag;
    samp_a = a; samp_b = b; fmt_twos = f; oe_n = oen; pwr_dn = pd; sleep = sl;
    @(posedge clk);
    tag = f ? "R4" : "R3";
    if (!pd && !sl) begin
      q.push_back('{a: a, b: b});
      adv_run++;
      if (q.size() > LAT) begin
        p = q.pop_front();
        exp_a = p.a ^ {f, {(W-1){1'b0}}};
        exp_b = p.b ^ {f, {(W-1){1'b0}}};
        have_exp = 1;
        if (f != last_f) tag = "R5";
      end
    end else begin
      adv_run = 0;
      tag = pd ? "R7" : "R8";
    end
    last_f = f;
    @(negedge clk);
    chk(drive_en == !oen, "R6", "drive_en", drive_en, !oen);
    chk(out_valid == (adv_run >= LAT + 1), "R9", "out_valid", out_valid,
        (adv_run >= LAT + 1));
    if (have_exp) begin
      chk(dout_a == exp_a, {tag, "/R2"}, "dout_a", dout_a, exp_a);
      chk(dout_b == exp_b, {tag, "/R10"}, "dout_b", dout_b, exp_b);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    do_reset(1'b1);
    // offset binary, including zero and both full scales (R3)
    step(10'h200, 10'h000, 0, 0, 0, 0);
    step(10'h000, 10'h3FF, 0, 0, 0, 0);
    step(10'h3FF, 10'h200, 0, 0, 0, 0);
    for (int i = 0; i < 12; i++)
      step(W'(i * 83 + 5), W'(1000 - i * 61), 0, 0, 0, 0);
    // two's complement (R4)
    step(10'h200, 10'h3FF, 1, 0, 0, 0);
    step(10'h3FF, 10'h000, 1, 0, 0, 0);
    step(10'h000, 10'h201, 1, 0, 0, 0);
    step(10'h1FF, 10'h200, 1, 0, 0, 0);
    for (int i = 0; i < 6; i++)
      step(W'(i * 131), W'(i * 7 + 512), 1, 0, 0, 0);
    // single-cycle format toggles (R5)
    for (int i = 0; i < 10; i++)
      step(W'(i * 97 + 3), W'(i * 45 + 700), (i % 3 == 1), 0, 0, 0);
    // power-down with outputs enabled, then disabled (R7, R6)
    for (int i = 0; i < 4; i++) step(W'(i + 900), W'(i + 11), i[0], 0, 1, 0);
    for (int i = 0; i < 3; i++) step(W'(i + 50), W'(i + 60), 0, 1, 1, 0);
    for (int i = 0; i < 8; i++) step(W'(i * 17 + 300), W'(i * 29), 0, 0, 0, 0);
    // sleep with stale words in the path (R8, R9)
    for (int i = 0; i < 3; i++) step(W'(i + 444), W'(i + 555), 0, 0, 0, 1);
    for (int i = 0; i < 9; i++) step(W'(i * 71 + 1), W'(i * 33 + 2), 1, 0, 0, 0);
    // short sleep glitch then stream
    step(10'h155, 10'h2AA, 0, 1, 0, 1);
    for (int i = 0; i < 8; i++) step(W'(i * 19), W'(1023 - i), 0, 0, 0, 0);
    // reset mid-stream (R1)
    do_reset(1'b0);
    for (int i = 0; i < 8; i++) step(W'(i * 123 + 9), W'(i * 5 + 77), 1, 0, 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule